// File: doc/BRIEF.md
# Time-Partition Scheduler with Per-Partition Interrupt Holding

This block divides processor time into fixed partitions. A trusted-mode table lists, for each slot, the partition that runs and the number of clock ticks it receives. The scheduler walks the table in round-robin order and wraps to slot zero after the last slot. Slots with a zero allocation are passed over.

Each activation runs the same switch sequence. Interrupt enable is dropped first. The partition number of the slot is latched into the current-partition register. In the following cycle the slot's allocation is copied into the slice counter. A load request then asks the processor to restore that partition's context. The partition then runs for exactly its allocation. A save request stores its context, and the scheduler moves on to the next slot. Context transfer itself is represented only by the request and acknowledge handshakes.

Every incoming interrupt is tagged with the partition that owns it and a line number. It is recorded as a pending bit of that partition. While the current partition executes, its lowest pending line is offered to the processor, and acknowledging it clears that bit. Interrupts owned by other partitions stay held until their partition is next in execution.

Top module: `partition_scheduler`

## Requirements
- R1: After reset the current partition is 0. The load request, save request, execute, interrupt-enable and interrupt-request outputs are all low. Every table slot holds a zero allocation, so no partition executes until the table is written.
- R2: Slots are visited in ascending index order, and the scan wraps from the last slot to slot 0. Partitions therefore execute in the cyclic order given by the table.
- R3: A slot whose allocation is zero is skipped: no load request, no execution and no change of current partition for that slot. Each skipped slot costs one cycle.
- R4: A partition stays in execution for exactly its allocation in cycles. The remaining-slice output starts at the allocation and falls by one each execute cycle. The cycle after it reads 1, the save request rises.
- R5: The switch runs in a fixed order. First the current partition is updated. One cycle later the remaining-slice output shows the new allocation. Then the load request rises, and execution starts in the cycle after the load acknowledge.
- R6: The load and save requests stay high until their acknowledge is sampled high. At most one of load request, save request and execute is high at a time.
- R7: Interrupt enable is high only while executing. It is low from the start of a switch until the load acknowledge completes.
- R8: An interrupt that arrives for the executing partition is offered on the interrupt request in the cycle after it is sampled.
- R9: An interrupt for a partition that is not executing is not offered. It is held and offered once that partition is next in execution.
- R10: When several lines of the executing partition are pending, the lowest line number is offered first. An acknowledge while a request is offered clears that line, and the next line is offered in the following cycle.
- R11: Table writes take effect only when the trusted flag is high. A write with the flag low changes nothing.
- R12: If an interrupt for a line arrives in the same cycle as the acknowledge of that line, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgTrusted | input | 1 | Write is issued from trusted mode |
| cfgAddr | input | 3 | Table slot to write |
| cfgPart | input | 2 | Partition number for the slot |
| cfgSlice | input | 8 | Tick allocation for the slot (0 = skip) |
| irqIn | input | 1 | Interrupt arrival strobe |
| irqPart | input | 2 | Owning partition of the arriving interrupt |
| irqLine | input | 2 | Line number of the arriving interrupt |
| irqAck | input | 1 | Processor accepts the offered interrupt |
| loadAck | input | 1 | Context load finished |
| saveAck | input | 1 | Context save finished |
| loadReq | output | 1 | Request to load the incoming partition's context |
| saveReq | output | 1 | Request to save the outgoing partition's context |
| execActive | output | 1 | Current partition is executing |
| intEnable | output | 1 | Interrupt delivery is enabled |
| curPart | output | 2 | Current-partition register |
| sliceLeft | output | 8 | Ticks remaining in the current slice |
| irqReq | output | 1 | An interrupt of the current partition is offered |
| irqId | output | 2 | Line number of the offered interrupt |

## Verification
The hardest case to reach from the ports is an interrupt that must survive several switches. It has to be raised while a different partition executes, stay held through the save, skip and load phases, and then appear in the very first execute cycle of its owner. A close second is an arrival on a line in the same cycle as that line's acknowledge. The stimulus reaches both by polling the ports until a chosen partition is in its first execute cycle, which is the cycle where the remaining-slice output equals the allocation. It then injects interrupts for the partition that runs next and waits for that partition's first execute cycle. A long pseudo-random phase varies the acknowledge delays and interrupt traffic, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [2:0] {
    PH_PICK,
    PH_ARM,
    PH_LOAD,
    PH_RUN,
    PH_SAVE
  } phase_e;

  typedef struct packed {
    logic latchPart;
    logic loadCount;
    logic decCount;
    logic advanceIdx;
  } step_t;

endpackage

// File: rtl/tps_datapath.sv
module tps_datapath
  import tps_pkg::*;
#(
  parameter int NUM_PART    = 4,
  parameter int TABLE_DEPTH = 8,
  parameter int SLICE_W     = 8,
  parameter int NUM_LINES   = 4,
  localparam int PART_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
  localparam int IDX_W  = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  step_t              step,
  input  logic               intEnable,
  input  logic               cfgWrEn,
  input  logic               cfgTrusted,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [PART_W-1:0]  cfgPart,
  input  logic [SLICE_W-1:0] cfgSlice,
  input  logic               irqIn,
  input  logic [PART_W-1:0]  irqPart,
  input  logic [LINE_W-1:0]  irqLine,
  input  logic               irqAck,
  output logic               entryZero,
  output logic               countOne,
  output logic [PART_W-1:0]  curPart,
  output logic [SLICE_W-1:0] sliceLeft,
  output logic               irqReq,
  output logic [LINE_W-1:0]  irqId
);

  logic [PART_W-1:0]  tblPart  [TABLE_DEPTH];
  logic [SLICE_W-1:0] tblSlice [TABLE_DEPTH];
  logic [IDX_W-1:0]   slotIdx;
  logic [SLICE_W-1:0] count;
  logic [NUM_PART-1:0][NUM_LINES-1:0] pend;
  logic [NUM_PART-1:0][NUM_LINES-1:0] pendNext;
  logic [NUM_LINES-1:0] curPend;

  // schedule table, writable from trusted mode only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_DEPTH; i++) begin
        tblPart[i]  <= '0;
        tblSlice[i] <= '0;
      end
    end else if (cfgWrEn && cfgTrusted) begin
      tblPart[cfgAddr]  <= cfgPart;
      tblSlice[cfgAddr] <= cfgSlice;
    end
  end

  assign entryZero = (tblSlice[slotIdx] == '0);
  assign countOne  = (count <= SLICE_W'(1));

  // slot index, current partition and slice counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
      curPart <= '0;
      count   <= '0;
    end else begin
      if (step.advanceIdx)
        slotIdx <= (slotIdx == IDX_W'(TABLE_DEPTH - 1)) ? '0 : slotIdx + 1'b1;
      if (step.latchPart)
        curPart <= tblPart[slotIdx];
      if (step.loadCount)
        count <= tblSlice[slotIdx];
      else if (step.decCount && count != '0)
        count <= count - 1'b1;
    end
  end

  assign sliceLeft = count;

  // pending bits of the current partition
  always_comb begin
    curPend = '0;
    for (int p = 0; p < NUM_PART; p++)
      if (curPart == PART_W'(p)) curPend = pend[p];
  end

  // lowest pending line wins
  always_comb begin
    irqId = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (curPend[i]) irqId = LINE_W'(i);
  end

  assign irqReq = intEnable && (|curPend);

  // clear on acknowledge, then set on arrival so a new arrival is kept
  always_comb begin
    pendNext = pend;
    for (int p = 0; p < NUM_PART; p++) begin
      if (irqReq && irqAck && curPart == PART_W'(p))
        pendNext[p][irqId] = 1'b0;
      if (irqIn && irqPart == PART_W'(p))
        pendNext[p][irqLine] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else       pend <= pendNext;
  end

endmodule

// File: rtl/tps_control.sv
module tps_control
  import tps_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  entryZero,
  input  logic  countOne,
  input  logic  loadAck,
  input  logic  saveAck,
  output step_t step,
  output logic  loadReq,
  output logic  saveReq,
  output logic  execActive,
  output logic  intEnable
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_PICK;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    step      = '0;
    unique case (phase)
      PH_PICK: begin
        if (entryZero) begin
          step.advanceIdx = 1'b1;
        end else begin
          step.latchPart = 1'b1;
          phaseNext      = PH_ARM;
        end
      end
      PH_ARM: begin
        step.loadCount = 1'b1;
        phaseNext      = PH_LOAD;
      end
      PH_LOAD: begin
        if (loadAck) phaseNext = PH_RUN;
      end
      PH_RUN: begin
        step.decCount = 1'b1;
        if (countOne) phaseNext = PH_SAVE;
      end
      PH_SAVE: begin
        if (saveAck) begin
          step.advanceIdx = 1'b1;
          phaseNext       = PH_PICK;
        end
      end
      default: phaseNext = PH_PICK;
    endcase
  end

  assign loadReq    = (phase == PH_LOAD);
  assign saveReq    = (phase == PH_SAVE);
  assign execActive = (phase == PH_RUN);
  assign intEnable  = (phase == PH_RUN);

endmodule

// File: rtl/partition_scheduler.sv
module partition_scheduler
  import tps_pkg::*;
#(
  parameter int NUM_PART    = 4,
  parameter int TABLE_DEPTH = 8,
  parameter int SLICE_W     = 8,
  parameter int NUM_LINES   = 4,
  localparam int PART_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
  localparam int IDX_W  = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgTrusted,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic [PART_W-1:0]  cfgPart,
  input  logic [SLICE_W-1:0] cfgSlice,
  input  logic               irqIn,
  input  logic [PART_W-1:0]  irqPart,
  input  logic [LINE_W-1:0]  irqLine,
  input  logic               irqAck,
  input  logic               loadAck,
  input  logic               saveAck,
  output logic               loadReq,
  output logic               saveReq,
  output logic               execActive,
  output logic               intEnable,
  output logic [PART_W-1:0]  curPart,
  output logic [SLICE_W-1:0] sliceLeft,
  output logic               irqReq,
  output logic [LINE_W-1:0]  irqId
);

  step_t step;
  logic  entryZero;
  logic  countOne;

  tps_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .entryZero  (entryZero),
    .countOne   (countOne),
    .loadAck    (loadAck),
    .saveAck    (saveAck),
    .step       (step),
    .loadReq    (loadReq),
    .saveReq    (saveReq),
    .execActive (execActive),
    .intEnable  (intEnable)
  );

  tps_datapath #(
    .NUM_PART    (NUM_PART),
    .TABLE_DEPTH (TABLE_DEPTH),
    .SLICE_W     (SLICE_W),
    .NUM_LINES   (NUM_LINES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .step       (step),
    .intEnable  (intEnable),
    .cfgWrEn    (cfgWrEn),
    .cfgTrusted (cfgTrusted),
    .cfgAddr    (cfgAddr),
    .cfgPart    (cfgPart),
    .cfgSlice   (cfgSlice),
    .irqIn      (irqIn),
    .irqPart    (irqPart),
    .irqLine    (irqLine),
    .irqAck     (irqAck),
    .entryZero  (entryZero),
    .countOne   (countOne),
    .curPart    (curPart),
    .sliceLeft  (sliceLeft),
    .irqReq     (irqReq),
    .irqId      (irqId)
  );

endmodule

// File: rtl/partition_scheduler_chk.sv
module partition_scheduler_chk #(
  parameter int PART_W  = 2,
  parameter int SLICE_W = 8,
  parameter int LINE_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadAck,
  input logic               saveAck,
  input logic               loadReq,
  input logic               saveReq,
  input logic               execActive,
  input logic               intEnable,
  input logic [PART_W-1:0]  curPart,
  input logic [SLICE_W-1:0] sliceLeft,
  input logic               irqReq,
  input logic [LINE_W-1:0]  irqId
);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({loadReq, saveReq, execActive}) <= 1);                                   // R6
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    loadReq && !loadAck |=> loadReq);                                                  // R6
  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    saveReq && !saveAck |=> saveReq);                                                  // R6
  AST_LOAD_TO_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    loadReq && loadAck |=> execActive);                                                // R5
  AST_SLICE_DEC: assert property (@(posedge clk) disable iff (!rstN)
    execActive && sliceLeft > SLICE_W'(1) |=> execActive && sliceLeft == SLICE_W'($past(sliceLeft) - 1'b1)); // R4
  AST_SLICE_END: assert property (@(posedge clk) disable iff (!rstN)
    execActive && sliceLeft <= SLICE_W'(1) |=> saveReq);                                // R4
  AST_PART_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    execActive && sliceLeft > SLICE_W'(1) |=> $stable(curPart));                       // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> intEnable && execActive);                                               // R7

endmodule

bind partition_scheduler partition_scheduler_chk #(
  .PART_W  (PART_W),
  .SLICE_W (SLICE_W),
  .LINE_W  (LINE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadAck    (loadAck),
  .saveAck    (saveAck),
  .loadReq    (loadReq),
  .saveReq    (saveReq),
  .execActive (execActive),
  .intEnable  (intEnable),
  .curPart    (curPart),
  .sliceLeft  (sliceLeft),
  .irqReq     (irqReq),
  .irqId      (irqId)
);

// File: tb/partition_scheduler_tb.sv
module partition_scheduler_tb;

  localparam int NP = 4;
  localparam int TD = 8;
  localparam int SW = 8;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgTrusted = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [1:0] cfgPart = '0;
  logic [SW-1:0] cfgSlice = '0;
  logic irqIn, irqAck;
  logic [1:0] irqPart, irqLine;
  logic loadAck = 1'b0, saveAck = 1'b0;
  logic loadReq, saveReq, execActive, intEnable, irqReq;
  logic [1:0] curPart, irqId;
  logic [SW-1:0] sliceLeft;

  // manual and automatic interrupt stimulus
  logic mIrq = 1'b0, mAck = 1'b0;
  logic [1:0] mPart = '0, mLine = '0;
  logic aIrq = 1'b0, aAck = 1'b0;
  logic [1:0] aPart = '0, aLine = '0;
  logic autoOn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int ackDelay = 0;
  int reqAge = 0;

  assign irqIn   = autoOn ? aIrq  : mIrq;
  assign irqAck  = autoOn ? aAck  : mAck;
  assign irqPart = autoOn ? aPart : mPart;
  assign irqLine = autoOn ? aLine : mLine;

  always #2 clk = ~clk;

  partition_scheduler u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTrusted(cfgTrusted),
    .cfgAddr(cfgAddr), .cfgPart(cfgPart), .cfgSlice(cfgSlice),
    .irqIn(irqIn), .irqPart(irqPart), .irqLine(irqLine), .irqAck(irqAck),
    .loadAck(loadAck), .saveAck(saveAck), .loadReq(loadReq), .saveReq(saveReq),
    .execActive(execActive), .intEnable(intEnable), .curPart(curPart),
    .sliceLeft(sliceLeft), .irqReq(irqReq), .irqId(irqId)
  );

  int nVec = 0, nFail = 0, cyc = 0;
  bit done = 0;
  int order[$];
  bit prevExec = 0;

  // behavioural reference: 0 pick, 1 arm, 2 load, 3 run, 4 save
  int mPhase = 0, mIdx = 0, mCur = 0, mCnt = 0;
  int mPend[NP];
  int tPart[TD];
  int tSlice[TD];

  function automatic int lowestBit(int v);
    for (int i = 0; i < NL; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    int oCur, oId;
    bit oReq;
    if (!rstN) begin
      mPhase = 0; mIdx = 0; mCur = 0; mCnt = 0;
      for (int i = 0; i < NP; i++) mPend[i] = 0;
      for (int i = 0; i < TD; i++) begin tPart[i] = 0; tSlice[i] = 0; end
    end else begin
      oCur = mCur;
      oReq = (mPhase == 3) && (mPend[mCur] != 0);
      oId  = lowestBit(mPend[mCur]);
      case (mPhase)
        0: if (tSlice[mIdx] == 0) mIdx = (mIdx + 1) % TD;
           else begin mCur = tPart[mIdx]; mPhase = 1; end
        1: begin mCnt = tSlice[mIdx]; mPhase = 2; end
        2: if (loadAck) mPhase = 3;
        3: if (mCnt <= 1) begin mCnt = 0; mPhase = 4; end else mCnt = mCnt - 1;
        4: if (saveAck) begin mIdx = (mIdx + 1) % TD; mPhase = 0; end
        default: mPhase = 0;
      endcase
      if (oReq && irqAck) mPend[oCur] = mPend[oCur] & ~(1 << oId);
      if (irqIn) mPend[irqPart] = mPend[irqPart] | (1 << irqLine);
      if (cfgWrEn && cfgTrusted) begin
        tPart[cfgAddr]  = cfgPart;
        tSlice[cfgAddr] = cfgSlice;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 curPart", curPart, mCur);
      chk("R6 loadReq", loadReq, mPhase == 2);
      chk("R6 saveReq", saveReq, mPhase == 4);
      chk("R4 execActive", execActive, mPhase == 3);
      chk("R7 intEnable", intEnable, mPhase == 3);
      chk("R4 sliceLeft", sliceLeft, mCnt);
      chk("R9 irqReq", irqReq, (mPhase == 3) && (mPend[mCur] != 0));
      if (irqReq) chk("R10 irqId", irqId, lowestBit(mPend[mCur]));
      if (execActive && !prevExec) order.push_back(int'(curPart));
      prevExec = execActive;
    end
  end

  // acknowledge responder and automatic interrupt traffic
  always @(negedge clk) begin
    if (!rstN) begin
      loadAck = 0; saveAck = 0; reqAge = 0;
    end else begin
      if (mPhase == 2 || mPhase == 4) reqAge++; else reqAge = 0;
      loadAck = (mPhase == 2) && (reqAge > ackDelay);
      saveAck = (mPhase == 4) && (reqAge > ackDelay);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      aIrq  = lfsr[0] & lfsr[3];
      aPart = lfsr[5:4];
      aLine = lfsr[7:6];
      aAck  = lfsr[9] & lfsr[2];
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finishRun();
    end
  end

  task automatic wr(bit trusted, int a, int p, int s);
    @(negedge clk);
    cfgWrEn = 1; cfgTrusted = trusted;
    cfgAddr = 3'(a); cfgPart = 2'(p); cfgSlice = SW'(s);
    @(negedge clk);
    cfgWrEn = 0; cfgTrusted = 0;
  endtask

  task automatic waitExecStart(int p, int s);
    do @(negedge clk); while (!(execActive && curPart == 2'(p) && sliceLeft == SW'(s)));
  endtask

  task automatic irqPulse(int p, int l);
    mIrq = 1; mPart = 2'(p); mLine = 2'(l);
    @(negedge clk);
    mIrq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 curPart", curPart, 0);
    chk("R1 loadReq", loadReq, 0);
    chk("R1 saveReq", saveReq, 0);
    chk("R1 execActive", execActive, 0);
    chk("R1 intEnable", intEnable, 0);
    chk("R1 irqReq", irqReq, 0);

    // R11 untrusted write leaves the empty table untouched
    wr(0, 0, 1, 5);
    repeat (20) @(negedge clk);
    chk("R11 no execution after untrusted write", order.size(), 0);
    chk("R1 still idle", loadReq, 0);

    // trusted schedule: slot1 and slots 4..7 zero (R3)
    wr(1, 3, 3, 2);
    wr(1, 2, 2, 5);
    wr(1, 0, 1, 6);

    // R5 switch order observed at load request of partition 2
    do @(negedge clk); while (!(loadReq && curPart == 2'd2));
    chk("R5 slice loaded before load request", sliceLeft, 5);
    chk("R7 interrupts disabled during load", intEnable, 0);

    // R8 interrupt for the running partition
    waitExecStart(2, 5);
    irqPulse(2, 3);
    chk("R8 irqReq next cycle", irqReq, 1);
    chk("R8 irqId", irqId, 3);
    // R9 interrupt for partition 3 is held
    irqPulse(3, 1);
    chk("R9 other partition not offered", irqId, 3);

    waitExecStart(3, 2);
    chk("R9 held interrupt offered", irqReq, 1);
    chk("R9 held line", irqId, 1);
    mAck = 1;
    @(negedge clk);
    mAck = 0;
    chk("R10 ack clears line", irqReq, 0);

    // R10 ordering and R12 collision for partition 1
    irqPulse(1, 2);
    irqPulse(1, 0);
    waitExecStart(1, 6);
    chk("R10 lowest first", irqId, 0);
    mAck = 1; mIrq = 1; mPart = 2'd1; mLine = 2'd0;
    @(negedge clk);
    mIrq = 0;
    chk("R12 arrival kept", irqReq, 1);
    chk("R12 same line still offered", irqId, 0);
    @(negedge clk);
    chk("R10 next line offered", irqId, 2);
    @(negedge clk);
    mAck = 0;
    chk("R10 all lines served", irqReq, 0);

    // R2 and R3: cyclic order 1 -> 2 -> 3 -> 1, partition 0 never runs
    for (int k = 0; k + 1 < order.size() && k < 4; k++)
      chk("R2 round-robin successor", order[k+1], (order[k] == 3) ? 1 : order[k] + 1);
    foreach (order[k]) chk("R3 zero slot skipped", order[k] == 0, 0);

    // pseudo-random phase
    ackDelay = 2;
    autoOn = 1;
    repeat (3000) @(negedge clk);
    autoOn = 0;
    chk("R2 schedule kept running", order.size() > 20, 1);
    finishRun();
  end

endmodule